// File: doc/BRIEF.md
# Serial CRC-8 Generator and Checker

This block computes an 8-bit cyclic redundancy remainder over a parameterised message word. It feeds the word into one linear feedback shift register, one bit per clock, most significant bit first. The generator polynomial is x^8 + x^4 + x^2 + 1. The same register serves two roles, chosen by a mode input that is sampled together with the word on a start strobe.

In generate mode, the low eight bits of the word are treated as zeros and the upper bits are the payload. When the word has been shifted through, the block presents a frame made of the payload followed by the remainder. In check mode, the whole word is shifted, including the received remainder field. The block then presents the payload if the final remainder is zero, or all zeros if it is not, and raises a pass flag to match.

A one-cycle done pulse marks each completed operation. Results hold until a later operation completes. A new start strobe abandons any operation in progress and clears the register.

Top module: `crc8_serial`

## Requirements
- R1: A synchronous active-high reset clears `frame_out`, `data_out`, `check_ok` and `done` to zero and abandons any operation, so no `done` follows it.
- R2: When `start` is sampled high at a clock edge, `done` is high for exactly one cycle: the cycle that follows the MSG_W-th clock edge after that edge. It is low at every other time.
- R3: With `gen_mode`=1 at start, on completion `frame_out` equals `{msg_in[MSG_W-1:8], rem}`. Here `rem` is the remainder of `{msg_in[MSG_W-1:8], 8'h00}` divided by x^8+x^4+x^2+1 (the 9-bit divisor 0x115, word bit MSG_W-1 as the highest power). The low 8 bits of `msg_in` have no effect.
- R4: With `gen_mode`=0 at start, if the remainder of the whole `msg_in` divided by 0x115 is zero, then on completion `data_out` equals `msg_in[MSG_W-1:8]` and `check_ok` is 1.
- R5: With `gen_mode`=0 at start, if that remainder is nonzero, then on completion `data_out` is all zeros and `check_ok` is 0.
- R6: A generate completion sets `check_ok` to 0 and leaves `data_out` unchanged. A check completion leaves `frame_out` unchanged.
- R7: `frame_out`, `data_out` and `check_ok` change only at the edge that raises `done`. They hold their values while an operation is in progress.
- R8: A `start` sampled while an operation is running abandons that operation. The register is cleared and the count restarts from the new start.
- R9: `msg_in` and `gen_mode` are sampled only on the start edge. Changing them during shifting has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latches `msg_in` and `gen_mode` and begins an operation |
| gen_mode | input | 1 | 1 = generate remainder, 0 = check received word |
| msg_in | input | MSG_W | Parallel message word |
| frame_out | output | MSG_W | Payload with remainder appended (generate mode) |
| data_out | output | MSG_W-8 | Recovered payload, or zeros on failure (check mode) |
| done | output | 1 | One-cycle completion pulse |
| check_ok | output | 1 | 1 when the last check found a zero remainder |

## Verification
The assertions check the following on every cycle:
- `done` occurs only MSG_W cycles after the most recent start, and only for a single cycle.
- The outputs stay frozen in every cycle without `done`.
- A failed check yields a zero payload.
- A generate completion clears the pass flag and leaves the check-side outputs alone.

Only the bench scenarios can show that the remainder values themselves are correct. The bench compares them against long division by 0x115. It also round-trips generated frames through check mode, corrupts frames, and shows that late changes to the inputs, a restart in flight and a reset in flight leave the results as required.

// File: rtl/crc8_serial_pkg.sv
package crc8_serial_pkg;

    localparam int CRC_W = 8;
    // Feedback taps, bit i set when stage i receives the top stage (x^4, x^2, x^0)
    localparam logic [CRC_W-1:0] GEN_TAPS = 8'h15;

    typedef logic [CRC_W-1:0] crc_t;

    typedef enum logic {
        MODE_CHECK = 1'b0,
        MODE_GEN   = 1'b1
    } crc_mode_e;

    typedef struct packed {
        logic      shift;   // a bit is entering the register this cycle
        logic      last;    // final bit of the word
        logic      bit_in;  // the bit being shifted
        crc_mode_e mode;    // role latched at start
    } feed_ctl_t;

    function automatic logic remainder_clean(input crc_t r);
        return r == '0;
    endfunction

endpackage

// File: rtl/crc8_lfsr.sv
module crc8_lfsr
    import crc8_serial_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic shift,
    input  logic bit_in,
    output crc_t state,
    output crc_t next_state
);

    logic top;
    assign top = state[CRC_W-1];

    for (genvar i = 0; i < CRC_W; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign next_state[i] = bit_in ^ (GEN_TAPS[i] & top);
        end else begin : g_body
            assign next_state[i] = state[i-1] ^ (GEN_TAPS[i] & top);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state <= '0;
        end else if (shift) begin
            state <= next_state;
        end
    end

endmodule

// File: rtl/crc8_feeder.sv
module crc8_feeder
    import crc8_serial_pkg::*;
#(
    parameter int MSG_W = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   gen_mode,
    input  logic [MSG_W-1:0]       msg_in,
    output feed_ctl_t              ctl,
    output logic [MSG_W-CRC_W-1:0] payload
);

    localparam int CNT_W = $clog2(MSG_W + 1);
    localparam int PAY_W = MSG_W - CRC_W;

    logic [MSG_W-1:0] shreg;
    logic [CNT_W-1:0] remaining;
    logic             busy;
    crc_mode_e        mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            remaining <= '0;
            busy      <= 1'b0;
            mode_q    <= MODE_CHECK;
            payload   <= '0;
        end else if (start) begin
            mode_q    <= gen_mode ? MODE_GEN : MODE_CHECK;
            payload   <= msg_in[MSG_W-1:CRC_W];
            shreg     <= gen_mode ? {msg_in[MSG_W-1:CRC_W], {CRC_W{1'b0}}} : msg_in;
            remaining <= CNT_W'(MSG_W);
            busy      <= 1'b1;
        end else if (busy) begin
            shreg     <= {shreg[MSG_W-2:0], 1'b0};
            remaining <= remaining - 1'b1;
            if (remaining == CNT_W'(1)) begin
                busy <= 1'b0;
            end
        end
    end

    always_comb begin
        ctl.shift  = busy && !start;
        ctl.last   = busy && !start && (remaining == CNT_W'(1));
        ctl.bit_in = shreg[MSG_W-1];
        ctl.mode   = mode_q;
    end

    logic unused_width;
    assign unused_width = ^PAY_W[0];

endmodule

// File: rtl/crc8_result.sv
module crc8_result
    import crc8_serial_pkg::*;
#(
    parameter int MSG_W = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  feed_ctl_t              ctl,
    input  logic [MSG_W-CRC_W-1:0] payload,
    input  crc_t                   rem,
    output logic [MSG_W-1:0]       frame_out,
    output logic [MSG_W-CRC_W-1:0] data_out,
    output logic                   check_ok,
    output logic                   done
);

    logic clean;
    assign clean = remainder_clean(rem);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_out <= '0;
            data_out  <= '0;
            check_ok  <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= ctl.last;
            if (ctl.last) begin
                if (ctl.mode == MODE_GEN) begin
                    frame_out <= {payload, rem};
                    check_ok  <= 1'b0;
                end else begin
                    data_out  <= clean ? payload : '0;
                    check_ok  <= clean;
                end
            end
        end
    end

    logic unused_ctl;
    assign unused_ctl = ctl.shift ^ ctl.bit_in;

endmodule

// File: rtl/crc8_serial.sv
module crc8_serial
    import crc8_serial_pkg::*;
#(
    parameter int MSG_W = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   gen_mode,
    input  logic [MSG_W-1:0]       msg_in,
    output logic [MSG_W-1:0]       frame_out,
    output logic [MSG_W-CRC_W-1:0] data_out,
    output logic                   done,
    output logic                   check_ok
);

    feed_ctl_t             ctl;
    logic [MSG_W-CRC_W-1:0] payload;
    crc_t                  crc_state;
    crc_t                  crc_next;

    crc8_feeder #(.MSG_W(MSG_W)) u_feeder (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .gen_mode (gen_mode),
        .msg_in   (msg_in),
        .ctl      (ctl),
        .payload  (payload)
    );

    crc8_lfsr u_lfsr (
        .clk        (clk),
        .rst        (rst),
        .clear      (start),
        .shift      (ctl.shift),
        .bit_in     (ctl.bit_in),
        .state      (crc_state),
        .next_state (crc_next)
    );

    crc8_result #(.MSG_W(MSG_W)) u_result (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .payload   (payload),
        .rem       (crc_next),
        .frame_out (frame_out),
        .data_out  (data_out),
        .check_ok  (check_ok),
        .done      (done)
    );

    logic unused_state;
    assign unused_state = ^crc_state;

endmodule

// File: rtl/crc8_serial_checks.sv
module crc8_serial_checks
    import crc8_serial_pkg::*;
#(
    parameter int MSG_W = 64
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   start,
    input logic                   gen_mode,
    input logic [MSG_W-1:0]       frame_out,
    input logic [MSG_W-CRC_W-1:0] data_out,
    input logic                   done,
    input logic                   check_ok
);

    logic rst_q;
    logic armed;
    logic gen_q;
    int   since;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            armed <= 1'b0;
            gen_q <= 1'b0;
            since <= 0;
        end else if (start) begin
            armed <= 1'b1;
            gen_q <= gen_mode;
            since <= 0;
        end else if (armed && since <= MSG_W) begin
            since <= since + 1;
        end
    end

    // R2: done only MSG_W edges after the latest start
    a_r2_done_timing: assert property (@(posedge clk) disable iff (rst || rst_q)
        done |-> (armed && since == MSG_W));

    // R2: done lasts one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst || rst_q)
        done |=> !done);

    // R7: results frozen outside completion
    a_r7_hold: assert property (@(posedge clk) disable iff (rst || rst_q)
        !done |-> ($stable(frame_out) && $stable(data_out) && $stable(check_ok)));

    // R5: a failed check gives a zero payload
    a_r5_zero_on_fail: assert property (@(posedge clk) disable iff (rst || rst_q)
        (done && !gen_q && !check_ok) |-> (data_out == '0));

    // R6: generate completion clears pass flag, keeps data_out
    a_r6_gen_side: assert property (@(posedge clk) disable iff (rst || rst_q)
        (done && gen_q) |-> (!check_ok && $stable(data_out)));

    // R6: check completion keeps frame_out
    a_r6_check_side: assert property (@(posedge clk) disable iff (rst || rst_q)
        (done && !gen_q) |-> $stable(frame_out));

endmodule

bind crc8_serial crc8_serial_checks #(.MSG_W(MSG_W)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .gen_mode  (gen_mode),
    .frame_out (frame_out),
    .data_out  (data_out),
    .done      (done),
    .check_ok  (check_ok)
);

// File: tb/crc8_serial_test.sv
module crc8_serial_test;

    localparam int W  = 64;
    localparam int PW = W - 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          gen_mode = 1'b0;
    logic [W-1:0]  msg_in = '0;
    logic [W-1:0]  frame_out;
    logic [PW-1:0] data_out;
    logic          done;
    logic          check_ok;

    int total = 0;
    int fails = 0;

    logic [W-1:0]  exp_frame = '0;
    logic [PW-1:0] exp_data  = '0;
    logic          exp_ok    = 1'b0;

    always #5 clk = ~clk;

    crc8_serial #(.MSG_W(W)) uut (
        .clk(clk), .rst(rst), .start(start), .gen_mode(gen_mode), .msg_in(msg_in),
        .frame_out(frame_out), .data_out(data_out), .done(done), .check_ok(check_ok)
    );

    // Remainder by long division with divisor 0x115
    function automatic logic [7:0] ref_rem(input logic [W-1:0] w);
        logic [W-1:0] v = w;
        for (int i = W - 1; i >= 8; i--) begin
            if (v[i]) v[i -: 9] = v[i -: 9] ^ 9'h115;
        end
        return v[7:0];
    endfunction

    function automatic logic [W-1:0] rand_word();
        logic [W-1:0] w = '0;
        for (int i = 0; i < W; i += 32) w = (w << 32) | W'($urandom());
        return w;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        chk(frame_out == exp_frame, {tag, " frame_out"}, frame_out, exp_frame);
        chk(data_out == exp_data, {tag, " data_out"}, W'(data_out), W'(exp_data));
        chk(check_ok == exp_ok, {tag, " check_ok"}, W'(check_ok), W'(exp_ok));
    endtask

    task automatic run_op(input logic m, input logic [W-1:0] w, input logic scramble);
        logic early = 1'b0;
        logic [7:0] r;
        @(negedge clk);
        start = 1'b1; gen_mode = m; msg_in = w;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin msg_in = rand_word(); gen_mode = ~m; end
        for (int k = 1; k < W; k++) begin
            @(negedge clk);
            if (done) early = 1'b1;
            if (scramble && k == W / 2) begin msg_in = ~msg_in; gen_mode = m; end
        end
        chk(!early, "R2 early done", W'(early), '0);
        check_outputs("R7 hold");
        @(negedge clk);
        chk(done == 1'b1, "R2 done pulse", W'(done), 1);
        if (m) begin
            r = ref_rem({w[W-1:8], 8'h00});
            exp_frame = {w[W-1:8], r};
            exp_ok = 1'b0;
            check_outputs(scramble ? "R9 R3 R6 generate" : "R3 R6 generate");
        end else begin
            r = ref_rem(w);
            exp_ok = (r == 8'h00);
            exp_data = exp_ok ? w[W-1:8] : '0;
            check_outputs(exp_ok ? "R4 R6 check pass" : "R5 R6 check fail");
        end
        @(negedge clk);
        chk(done == 1'b0, "R2 single cycle", W'(done), 0);
    endtask

    initial begin
        #1_500_000;
        total++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [W-1:0] w;
        logic [W-1:0] fr;
        logic any_done;
        void'($urandom(32'd20240607));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_outputs("R1 reset");
        chk(done == 1'b0, "R1 reset done", W'(done), 0);

        // Directed corners
        run_op(1'b1, '0, 1'b0);
        run_op(1'b1, '1, 1'b0);                    // R3 low byte ignored
        fr = exp_frame;
        run_op(1'b0, fr, 1'b0);                     // R4 round trip
        run_op(1'b0, fr ^ (W'(1) << 20), 1'b0);     // R5 corrupted
        run_op(1'b0, '0, 1'b0);                     // R4 zero word passes
        run_op(1'b1, {W{1'b1}} ^ W'(8'h5A), 1'b1);  // R9 late input changes
        run_op(1'b0, W'(1), 1'b1);                  // R9 check, fails

        // Random mix, valid and corrupted frames
        for (int n = 0; n < 20; n++) begin
            w = rand_word();
            if (n % 3 == 0) begin
                run_op(1'b1, w, n % 2 == 1);
            end else if (n % 3 == 1) begin
                w[7:0] = ref_rem({w[W-1:8], 8'h00});
                run_op(1'b0, w, 1'b0);
            end else begin
                run_op(1'b0, w, 1'b1);
            end
        end

        // R8: restart while busy
        @(negedge clk);
        start = 1'b1; gen_mode = 1'b1; msg_in = rand_word();
        @(negedge clk);
        start = 1'b0;
        any_done = 1'b0;
        repeat (10) begin @(negedge clk); if (done) any_done = 1'b1; end
        chk(!any_done, "R8 abandoned op silent", W'(any_done), 0);
        w = rand_word();
        w[7:0] = ref_rem({w[W-1:8], 8'h00});
        run_op(1'b0, w, 1'b0);

        // R1: reset in flight
        @(negedge clk);
        start = 1'b1; gen_mode = 1'b1; msg_in = rand_word();
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_frame = '0; exp_data = '0; exp_ok = 1'b0;
        check_outputs("R1 mid reset");
        any_done = 1'b0;
        repeat (W + 3) begin @(negedge clk); if (done) any_done = 1'b1; end
        chk(!any_done, "R1 no done after reset", W'(any_done), 0);
        run_op(1'b1, rand_word(), 1'b0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule